// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

An in-order, 32-bit integer core with five stages: fetch, decode with register read, execute, memory access and writeback. It executes a small load/store instruction subset: five register-to-register operations (add, subtract, AND, OR, set-on-less-than), word load, word store and branch-on-equal. Instruction and data storage are small internal word arrays. A single loader port writes either array while the core is held in reset. Writebacks and stores are visible on two trace ports.

Forwarding from the two later stage registers into both execute operands lets dependent register operations run back to back. A load followed at once by a consumer costs one bubble. Branches compare and compute their target in decode, so every branch costs one bubble. A branch whose operand is still being produced waits in decode until the value can be forwarded or read. A stall freezes the program counter and the fetch/decode register and sends an all-zero control word into execute.

Top module: `pipe_core`

## Requirements
- R1: While reset is asserted, and after it is released, the core fetches from address 0, and the commit and store ports stay idle. The first instruction's writeback appears on the commit port after exactly 4 rising edges following reset release. Later instructions complete one per cycle when no hazard is present.
- R2: An instruction with opcode 000000 is decoded by its funct field in bits 5:0. The codes are 100000 add, 100010 sub, 100100 and, 100101 or, and 101010 signed set-on-less-than. The result goes to the register in bits 15:11, and any other funct value writes nothing.
- R3: Opcode 100011 loads a word and writes it to the register in bits 20:16. Opcode 101011 stores the register in bits 20:16. Both use the address given by register bits 25:21 plus the sign-extended bits 15:0, with the word index taken from address bits above bit 1.
- R4: A register operation that consumes the result of the instruction just before it, or of the one two ahead, completes in the next cycle with no bubble.
- R5: When both later stages hold a pending write to the same source register, the more recent result is used.
- R6: An instruction that reads the destination of a load still in execute is delayed by exactly one cycle, then receives the loaded word.
- R7: Opcode 000100 compares registers 25:21 and 20:16. When they are equal it jumps to PC+4 plus the sign-extended offset shifted left by 2. Taken or not, exactly one bubble follows it.
- R8: A branch whose operand is produced by a register operation in execute waits one cycle. One whose operand comes from a load in execute waits two cycles.
- R9: Register 0 reads as zero, a write to it is discarded and never forwarded, and no commit is shown for it.
- R10: A register written back in the same cycle it is read in decode delivers the new value.
- R11: The loader writes the instruction array when its select bit is 0 and the data array when it is 1, at the given word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_we_i | input | 1 | Loader write strobe |
| ld_sel_i | input | 1 | Loader target: 0 instruction array, 1 data array |
| ld_addr_i | input | LD_AW | Loader word index |
| ld_data_i | input | 32 | Loader write data |
| fetch_pc_o | output | 32 | Current fetch address |
| commit_valid_o | output | 1 | A register write takes effect this cycle |
| commit_rd_o | output | 5 | Register being written |
| commit_data_o | output | 32 | Value being written |
| store_valid_o | output | 1 | A store is in the memory stage |
| store_addr_o | output | 32 | Store byte address |
| store_data_o | output | 32 | Store data |

## Verification
An instruction at index i that is not delayed shows its writeback after i+4 rising edges from reset release. A store appears on the store port one edge earlier, at i+3. Each load-use stall and each branch bubble adds one edge to every later instruction, and a branch waiting on a load in execute adds two. The bench works out the edge count for each expected commit and store from these rules and records the edge number at which each event is seen on the falling edge. It compares rd, data and edge number, and also the total number of events, so a missing, extra or shifted bubble is caught.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
  localparam int XLEN = 32;
  localparam int RAW  = 5;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    FWD_REG   = 2'd0,
    FWD_EXMEM = 2'd1,
    FWD_MEMWB = 2'd2
  } fwd_e;

  typedef struct packed {
    logic    reg_write;
    logic    mem_read;
    logic    mem_write;
    logic    alu_src;
    alu_op_e alu_op;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '0;

  typedef struct packed {
    logic [XLEN-1:0] instr;
    logic [XLEN-1:0] pc4;
  } ifid_t;

  typedef struct packed {
    ctrl_t           ctrl;
    logic [RAW-1:0]  rs;
    logic [RAW-1:0]  rt;
    logic [RAW-1:0]  rd;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] imm;
  } idex_t;

  typedef struct packed {
    logic            reg_write;
    logic            mem_read;
    logic            mem_write;
    logic [RAW-1:0]  rd;
    logic [XLEN-1:0] res;
    logic [XLEN-1:0] sdata;
  } exmem_t;

  typedef struct packed {
    logic            reg_write;
    logic            mem_read;
    logic [RAW-1:0]  rd;
    logic [XLEN-1:0] res;
    logic [XLEN-1:0] ldata;
  } memwb_t;
endpackage

// File: rtl/pipe_decode.sv
module pipe_decode
  import pipe_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output ctrl_t           ctrl_o,
  output logic            branch_o,
  output logic            uses_rs_o,
  output logic            uses_rt_o,
  output logic [RAW-1:0]  rs_o,
  output logic [RAW-1:0]  rt_o,
  output logic [RAW-1:0]  dest_o,
  output logic [XLEN-1:0] imm_o
);
  logic [5:0] opcode;
  logic [5:0] funct;

  assign opcode = instr_i[31:26];
  assign funct  = instr_i[5:0];
  assign rs_o   = instr_i[25:21];
  assign rt_o   = instr_i[20:16];
  assign imm_o  = {{(XLEN-16){instr_i[15]}}, instr_i[15:0]};

  always_comb begin
    ctrl_o    = CTRL_NOP;
    branch_o  = 1'b0;
    uses_rs_o = 1'b0;
    uses_rt_o = 1'b0;
    dest_o    = '0;
    unique case (opcode)
      OP_RTYPE: begin
        dest_o = instr_i[15:11];
        unique case (funct)
          FN_ADD: ctrl_o.alu_op = ALU_ADD;
          FN_SUB: ctrl_o.alu_op = ALU_SUB;
          FN_AND: ctrl_o.alu_op = ALU_AND;
          FN_OR:  ctrl_o.alu_op = ALU_OR;
          FN_SLT: ctrl_o.alu_op = ALU_SLT;
          default: ctrl_o.alu_op = ALU_ADD;
        endcase
        if (funct inside {FN_ADD, FN_SUB, FN_AND, FN_OR, FN_SLT}) begin
          ctrl_o.reg_write = 1'b1;
          uses_rs_o        = 1'b1;
          uses_rt_o        = 1'b1;
        end
      end
      OP_LW: begin
        dest_o           = instr_i[20:16];
        ctrl_o.reg_write = 1'b1;
        ctrl_o.mem_read  = 1'b1;
        ctrl_o.alu_src   = 1'b1;
        uses_rs_o        = 1'b1;
      end
      OP_SW: begin
        ctrl_o.mem_write = 1'b1;
        ctrl_o.alu_src   = 1'b1;
        uses_rs_o        = 1'b1;
        uses_rt_o        = 1'b1;
      end
      OP_BEQ: begin
        branch_o  = 1'b1;
        uses_rs_o = 1'b1;
        uses_rt_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pipe_regfile.sv
module pipe_regfile
  import pipe_pkg::*;
#(
  parameter int NREGS = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RAW-1:0]  waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [RAW-1:0]  raddr_a_i,
  input  logic [RAW-1:0]  raddr_b_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o
);
  logic [XLEN-1:0] regs [NREGS];
  logic            wr_en;

  assign wr_en = we_i && (waddr_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_en) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  // write-first: a same-cycle writeback is visible to decode
  always_comb begin
    if (raddr_a_i == '0)                    rdata_a_o = '0;
    else if (wr_en && waddr_i == raddr_a_i) rdata_a_o = wdata_i;
    else                                    rdata_a_o = regs[raddr_a_i];
    if (raddr_b_i == '0)                    rdata_b_o = '0;
    else if (wr_en && waddr_i == raddr_b_i) rdata_b_o = wdata_i;
    else                                    rdata_b_o = regs[raddr_b_i];
  end
endmodule

// File: rtl/pipe_alu.sv
module pipe_alu
  import pipe_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/pipe_hazard.sv
module pipe_hazard
  import pipe_pkg::*;
(
  input  logic           id_branch_i,
  input  logic           id_uses_rs_i,
  input  logic           id_uses_rt_i,
  input  logic [RAW-1:0] id_rs_i,
  input  logic [RAW-1:0] id_rt_i,
  input  logic           ex_reg_write_i,
  input  logic           ex_mem_read_i,
  input  logic [RAW-1:0] ex_rd_i,
  input  logic [RAW-1:0] ex_rs_i,
  input  logic [RAW-1:0] ex_rt_i,
  input  logic           mem_reg_write_i,
  input  logic           mem_mem_read_i,
  input  logic [RAW-1:0] mem_rd_i,
  input  logic           wb_reg_write_i,
  input  logic [RAW-1:0] wb_rd_i,
  output logic           stall_o,
  output fwd_e           fwd_a_o,
  output fwd_e           fwd_b_o,
  output logic           br_fwd_a_o,
  output logic           br_fwd_b_o
);
  logic mem_hit_a, mem_hit_b, wb_hit_a, wb_hit_b;
  logic ex_dep, mem_dep;
  logic load_use, branch_wait;

  // execute operand forwarding, newest producer first
  assign mem_hit_a = mem_reg_write_i && (mem_rd_i != '0) && (mem_rd_i == ex_rs_i);
  assign mem_hit_b = mem_reg_write_i && (mem_rd_i != '0) && (mem_rd_i == ex_rt_i);
  assign wb_hit_a  = wb_reg_write_i  && (wb_rd_i  != '0) && (wb_rd_i  == ex_rs_i);
  assign wb_hit_b  = wb_reg_write_i  && (wb_rd_i  != '0) && (wb_rd_i  == ex_rt_i);

  always_comb begin
    fwd_a_o = mem_hit_a ? FWD_EXMEM : (wb_hit_a ? FWD_MEMWB : FWD_REG);
    fwd_b_o = mem_hit_b ? FWD_EXMEM : (wb_hit_b ? FWD_MEMWB : FWD_REG);
  end

  // decode consumers of in-flight destinations
  assign ex_dep  = (ex_rd_i != '0) &&
                   ((id_uses_rs_i && ex_rd_i == id_rs_i) || (id_uses_rt_i && ex_rd_i == id_rt_i));
  assign mem_dep = (mem_rd_i != '0) &&
                   ((id_uses_rs_i && mem_rd_i == id_rs_i) || (id_uses_rt_i && mem_rd_i == id_rt_i));

  assign load_use    = ex_mem_read_i && ex_dep;
  assign branch_wait = id_branch_i && ((ex_reg_write_i && ex_dep) || (mem_mem_read_i && mem_dep));
  assign stall_o     = load_use || branch_wait;

  // comparator operands: ALU results in EX/MEM only
  assign br_fwd_a_o = mem_reg_write_i && !mem_mem_read_i && (mem_rd_i != '0) && (mem_rd_i == id_rs_i);
  assign br_fwd_b_o = mem_reg_write_i && !mem_mem_read_i && (mem_rd_i != '0) && (mem_rd_i == id_rt_i);
endmodule

// File: rtl/pipe_core.sv
module pipe_core
  import pipe_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IA_W  = $clog2(IMEM_WORDS),
  localparam int DA_W  = $clog2(DMEM_WORDS),
  localparam int LD_AW = (IA_W > DA_W) ? IA_W : DA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_we_i,
  input  logic             ld_sel_i,
  input  logic [LD_AW-1:0] ld_addr_i,
  input  logic [XLEN-1:0]  ld_data_i,
  output logic [XLEN-1:0]  fetch_pc_o,
  output logic             commit_valid_o,
  output logic [RAW-1:0]   commit_rd_o,
  output logic [XLEN-1:0]  commit_data_o,
  output logic             store_valid_o,
  output logic [XLEN-1:0]  store_addr_o,
  output logic [XLEN-1:0]  store_data_o
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc_q;
  ifid_t           ifid_q;
  idex_t           idex_q;
  exmem_t          exmem_q;
  memwb_t          memwb_q;

  // ---------------- fetch ----------------
  logic [XLEN-1:0] if_instr, if_pc4;
  assign if_instr = imem[pc_q[IA_W+1:2]];
  assign if_pc4   = pc_q + 32'd4;

  always_ff @(posedge clk_i) begin
    if (ld_we_i && !ld_sel_i) imem[ld_addr_i[IA_W-1:0]] <= ld_data_i;
  end

  // ---------------- decode ----------------
  ctrl_t           id_ctrl;
  logic            id_branch, id_uses_rs, id_uses_rt;
  logic [RAW-1:0]  id_rs, id_rt, id_dest;
  logic [XLEN-1:0] id_imm, rf_a, rf_b, br_a, br_b, br_target, wb_data;
  logic            stall, br_fwd_a, br_fwd_b, branch_fire, branch_taken;
  fwd_e            fwd_a, fwd_b;

  pipe_decode u_decode (
    .instr_i  (ifid_q.instr),
    .ctrl_o   (id_ctrl),
    .branch_o (id_branch),
    .uses_rs_o(id_uses_rs),
    .uses_rt_o(id_uses_rt),
    .rs_o     (id_rs),
    .rt_o     (id_rt),
    .dest_o   (id_dest),
    .imm_o    (id_imm)
  );

  pipe_regfile #(.NREGS(32)) u_regfile (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (memwb_q.reg_write),
    .waddr_i  (memwb_q.rd),
    .wdata_i  (wb_data),
    .raddr_a_i(id_rs),
    .raddr_b_i(id_rt),
    .rdata_a_o(rf_a),
    .rdata_b_o(rf_b)
  );

  pipe_hazard u_hazard (
    .id_branch_i    (id_branch),
    .id_uses_rs_i   (id_uses_rs),
    .id_uses_rt_i   (id_uses_rt),
    .id_rs_i        (id_rs),
    .id_rt_i        (id_rt),
    .ex_reg_write_i (idex_q.ctrl.reg_write),
    .ex_mem_read_i  (idex_q.ctrl.mem_read),
    .ex_rd_i        (idex_q.rd),
    .ex_rs_i        (idex_q.rs),
    .ex_rt_i        (idex_q.rt),
    .mem_reg_write_i(exmem_q.reg_write),
    .mem_mem_read_i (exmem_q.mem_read),
    .mem_rd_i       (exmem_q.rd),
    .wb_reg_write_i (memwb_q.reg_write),
    .wb_rd_i        (memwb_q.rd),
    .stall_o        (stall),
    .fwd_a_o        (fwd_a),
    .fwd_b_o        (fwd_b),
    .br_fwd_a_o     (br_fwd_a),
    .br_fwd_b_o     (br_fwd_b)
  );

  assign br_a         = br_fwd_a ? exmem_q.res : rf_a;
  assign br_b         = br_fwd_b ? exmem_q.res : rf_b;
  assign br_target    = ifid_q.pc4 + {id_imm[XLEN-3:0], 2'b00};
  assign branch_fire  = id_branch && !stall;
  assign branch_taken = branch_fire && (br_a == br_b);

  // ---------------- execute ----------------
  logic [XLEN-1:0] ex_a, ex_b, ex_alu_b, ex_res;

  always_comb begin
    unique case (fwd_a)
      FWD_EXMEM: ex_a = exmem_q.res;
      FWD_MEMWB: ex_a = wb_data;
      default:   ex_a = idex_q.a;
    endcase
    unique case (fwd_b)
      FWD_EXMEM: ex_b = exmem_q.res;
      FWD_MEMWB: ex_b = wb_data;
      default:   ex_b = idex_q.b;
    endcase
  end

  assign ex_alu_b = idex_q.ctrl.alu_src ? idex_q.imm : ex_b;

  pipe_alu u_alu (
    .op_i(idex_q.ctrl.alu_op),
    .a_i (ex_a),
    .b_i (ex_alu_b),
    .y_o (ex_res)
  );

  // ---------------- memory ----------------
  logic [XLEN-1:0] mem_rdata;
  assign mem_rdata = dmem[exmem_q.res[DA_W+1:2]];

  always_ff @(posedge clk_i) begin
    if (ld_we_i && ld_sel_i)    dmem[ld_addr_i[DA_W-1:0]] <= ld_data_i;
    else if (exmem_q.mem_write) dmem[exmem_q.res[DA_W+1:2]] <= exmem_q.sdata;
  end

  // ---------------- writeback ----------------
  assign wb_data = memwb_q.mem_read ? memwb_q.ldata : memwb_q.res;

  // ---------------- stage registers ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      ifid_q  <= '0;
      idex_q  <= '0;
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      if (!stall) begin
        if (branch_fire) pc_q <= branch_taken ? br_target : ifid_q.pc4;
        else             pc_q <= if_pc4;
      end

      if (branch_fire)  ifid_q <= '0;
      else if (!stall)  ifid_q <= '{instr: if_instr, pc4: if_pc4};

      if (stall) begin
        idex_q <= '0;
      end else begin
        idex_q.ctrl <= id_ctrl;
        idex_q.rs   <= id_rs;
        idex_q.rt   <= id_rt;
        idex_q.rd   <= id_dest;
        idex_q.a    <= rf_a;
        idex_q.b    <= rf_b;
        idex_q.imm  <= id_imm;
      end

      exmem_q.reg_write <= idex_q.ctrl.reg_write;
      exmem_q.mem_read  <= idex_q.ctrl.mem_read;
      exmem_q.mem_write <= idex_q.ctrl.mem_write;
      exmem_q.rd        <= idex_q.rd;
      exmem_q.res       <= ex_res;
      exmem_q.sdata     <= ex_b;

      memwb_q.reg_write <= exmem_q.reg_write;
      memwb_q.mem_read  <= exmem_q.mem_read;
      memwb_q.rd        <= exmem_q.rd;
      memwb_q.res       <= exmem_q.res;
      memwb_q.ldata     <= mem_rdata;
    end
  end

  assign fetch_pc_o     = pc_q;
  assign commit_valid_o = memwb_q.reg_write && (memwb_q.rd != '0);
  assign commit_rd_o    = memwb_q.rd;
  assign commit_data_o  = wb_data;
  assign store_valid_o  = exmem_q.mem_write;
  assign store_addr_o   = exmem_q.res;
  assign store_data_o   = exmem_q.sdata;
endmodule

// File: rtl/pipe_core_chk.sv
module pipe_core_chk
  import pipe_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            stall_i,
  input logic            branch_fire_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] ifid_instr_i,
  input logic            id_uses_rs_i,
  input logic [RAW-1:0]  id_rs_i,
  input logic            ex_reg_write_i,
  input logic            ex_mem_read_i,
  input logic            ex_mem_write_i,
  input logic [RAW-1:0]  ex_rd_i,
  input logic [RAW-1:0]  ex_rs_i,
  input logic            mem_reg_write_i,
  input logic [RAW-1:0]  mem_rd_i,
  input logic [XLEN-1:0] mem_res_i,
  input logic [XLEN-1:0] alu_a_i
);
  // R6
  stall_pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(pc_i));

  // R6
  stall_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> (!ex_reg_write_i && !ex_mem_write_i && !ex_mem_read_i));

  // R6
  load_use_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_mem_read_i && ex_rd_i != '0 && id_uses_rs_i && id_rs_i == ex_rd_i) |-> stall_i);

  // R7
  branch_bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_fire_i |=> (ifid_instr_i == '0));

  // R5
  fwd_newest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_reg_write_i && mem_rd_i != '0 && mem_rd_i == ex_rs_i) |-> (alu_a_i == mem_res_i));

  // R9
  zero_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rs_i == '0) |-> (alu_a_i == '0));
endmodule

bind pipe_core pipe_core_chk u_pipe_core_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .stall_i        (stall),
  .branch_fire_i  (branch_fire),
  .pc_i           (pc_q),
  .ifid_instr_i   (ifid_q.instr),
  .id_uses_rs_i   (id_uses_rs),
  .id_rs_i        (id_rs),
  .ex_reg_write_i (idex_q.ctrl.reg_write),
  .ex_mem_read_i  (idex_q.ctrl.mem_read),
  .ex_mem_write_i (idex_q.ctrl.mem_write),
  .ex_rd_i        (idex_q.rd),
  .ex_rs_i        (idex_q.rs),
  .mem_reg_write_i(exmem_q.reg_write),
  .mem_rd_i       (exmem_q.rd),
  .mem_res_i      (exmem_q.res),
  .alu_a_i        (ex_a)
);

// File: tb/pipe_core_bench.sv
module pipe_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LD_AW = 6;

  localparam logic [5:0] OP_LW  = 6'b100011;
  localparam logic [5:0] OP_SW  = 6'b101011;
  localparam logic [5:0] OP_BEQ = 6'b000100;
  localparam logic [5:0] F_ADD = 6'b100000;
  localparam logic [5:0] F_SUB = 6'b100010;
  localparam logic [5:0] F_AND = 6'b100100;
  localparam logic [5:0] F_OR  = 6'b100101;
  localparam logic [5:0] F_SLT = 6'b101010;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ld_we = 1'b0;
  logic             ld_sel = 1'b0;
  logic [LD_AW-1:0] ld_addr = '0;
  logic [31:0]      ld_data = '0;
  logic [31:0]      fetch_pc;
  logic             commit_valid, store_valid;
  logic [4:0]       commit_rd;
  logic [31:0]      commit_data, store_addr, store_data;

  pipe_core u_pipe_core (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .ld_we_i       (ld_we),
    .ld_sel_i      (ld_sel),
    .ld_addr_i     (ld_addr),
    .ld_data_i     (ld_data),
    .fetch_pc_o    (fetch_pc),
    .commit_valid_o(commit_valid),
    .commit_rd_o   (commit_rd),
    .commit_data_o (commit_data),
    .store_valid_o (store_valid),
    .store_addr_o  (store_addr),
    .store_data_o  (store_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit running = 1'b0;

  logic [31:0] prog [64];
  logic [31:0] dat  [16];

  logic [4:0]  cm_rd   [64];
  logic [31:0] cm_data [64];
  int          cm_cyc  [64];
  int          cm_n = 0;
  logic [31:0] st_addr [64];
  logic [31:0] st_data [64];
  int          st_cyc  [64];
  int          st_n = 0;

  always @(posedge clk) if (running) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (running && commit_valid && cm_n < 64) begin
      cm_rd[cm_n] = commit_rd; cm_data[cm_n] = commit_data; cm_cyc[cm_n] = cyc;
      cm_n = cm_n + 1;
    end
    if (running && store_valid && st_n < 64) begin
      st_addr[st_n] = store_addr; st_data[st_n] = store_data; st_cyc[st_n] = cyc;
      st_n = st_n + 1;
    end
  end

  function automatic logic [31:0] r_ins(logic [5:0] fn, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
    return {6'b000000, rs, rt, rd, 5'b00000, fn};
  endfunction

  function automatic logic [31:0] i_ins(logic [5:0] op, logic [4:0] rt, logic [4:0] rs, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expect_commit(input int k, input logic [4:0] rd, input logic [31:0] d,
                               input int c, input string req);
    if (k >= cm_n) begin
      chk(1'b0, req, $sformatf("commit %0d missing", k), cm_n, k + 1);
    end else begin
      chk(cm_rd[k] == rd, req, $sformatf("commit %0d rd", k), cm_rd[k], rd);
      chk(cm_data[k] == d, req, $sformatf("commit %0d data", k), cm_data[k], d);
      chk(cm_cyc[k] == c, req, $sformatf("commit %0d cycle", k), cm_cyc[k], c);
    end
  endtask

  task automatic expect_store(input int k, input logic [31:0] a, input logic [31:0] d,
                              input int c, input string req);
    if (k >= st_n) begin
      chk(1'b0, req, $sformatf("store %0d missing", k), st_n, k + 1);
    end else begin
      chk(st_addr[k] == a, req, $sformatf("store %0d addr", k), st_addr[k], a);
      chk(st_data[k] == d, req, $sformatf("store %0d data", k), st_data[k], d);
      chk(st_cyc[k] == c, req, $sformatf("store %0d cycle", k), st_cyc[k], c);
    end
  endtask

  task automatic clear_bufs();
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    for (int i = 0; i < 16; i++) dat[i] = 32'h0;
  endtask

  // R11: select 0 fills instructions, select 1 fills data words
  task automatic load_and_start();
    running = 1'b0;
    rst_ni  = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      ld_we = 1'b1; ld_sel = 1'b0; ld_addr = LD_AW'(i); ld_data = prog[i];
      @(negedge clk);
    end
    for (int i = 0; i < 16; i++) begin
      ld_we = 1'b1; ld_sel = 1'b1; ld_addr = LD_AW'(i); ld_data = dat[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
    chk(commit_valid == 1'b0, "R1", "commit idle in reset", 32'(commit_valid), 32'h0);
    chk(fetch_pc == 32'h0, "R1", "pc in reset", fetch_pc, 32'h0);
    cm_n = 0; st_n = 0; cyc = 0;
    rst_ni = 1'b1;
    running = 1'b1;
  endtask

  task automatic test_alu_chain();
    clear_bufs();
    dat[0] = 32'd7; dat[1] = 32'd5; dat[2] = 32'hFFFF_FFF0; dat[3] = 32'h0F0F_00FF;
    prog[0] = i_ins(OP_LW, 5'd1, 5'd0, 16'd0);
    prog[1] = i_ins(OP_LW, 5'd2, 5'd0, 16'd4);
    prog[2] = i_ins(OP_LW, 5'd3, 5'd0, 16'd8);
    prog[3] = i_ins(OP_LW, 5'd5, 5'd0, 16'd12);
    prog[4] = r_ins(F_ADD, 5'd4, 5'd1, 5'd2);
    prog[5] = r_ins(F_SUB, 5'd6, 5'd4, 5'd1);
    prog[6] = r_ins(F_AND, 5'd7, 5'd6, 5'd5);
    prog[7] = r_ins(F_OR,  5'd8, 5'd4, 5'd3);
    prog[8] = r_ins(F_SLT, 5'd9, 5'd3, 5'd1);
    prog[9] = r_ins(F_SLT, 5'd10, 5'd1, 5'd3);
    load_and_start();
    chk(fetch_pc == 32'h0, "R1", "pc at release", fetch_pc, 32'h0);
    chk(store_valid == 1'b0, "R1", "store idle at release", 32'(store_valid), 32'h0);
    repeat (30) @(negedge clk);
    chk(cm_n == 10, "R1", "commit count alu", cm_n, 10);
    expect_commit(0, 5'd1, 32'd7, 4, "R1");
    expect_commit(1, 5'd2, 32'd5, 5, "R3");
    expect_commit(2, 5'd3, 32'hFFFF_FFF0, 6, "R3");
    expect_commit(3, 5'd5, 32'h0F0F_00FF, 7, "R11");
    expect_commit(4, 5'd4, 32'd12, 8, "R10");
    expect_commit(5, 5'd6, 32'd5, 9, "R4");
    expect_commit(6, 5'd7, 32'd5, 10, "R2");
    expect_commit(7, 5'd8, 32'hFFFF_FFFC, 11, "R2");
    expect_commit(8, 5'd9, 32'd1, 12, "R2");
    expect_commit(9, 5'd10, 32'd0, 13, "R2");
  endtask

  task automatic test_priority_zero();
    clear_bufs();
    dat[0] = 32'd7; dat[1] = 32'd5;
    prog[0] = i_ins(OP_LW, 5'd1, 5'd0, 16'd0);
    prog[1] = i_ins(OP_LW, 5'd2, 5'd0, 16'd4);
    prog[2] = 32'h0;
    prog[3] = r_ins(F_ADD, 5'd3, 5'd1, 5'd2);
    prog[4] = r_ins(F_ADD, 5'd3, 5'd3, 5'd1);
    prog[5] = r_ins(F_ADD, 5'd3, 5'd3, 5'd2);
    prog[6] = r_ins(F_ADD, 5'd4, 5'd3, 5'd0);
    prog[7] = r_ins(F_ADD, 5'd0, 5'd1, 5'd2);
    prog[8] = r_ins(F_ADD, 5'd5, 5'd0, 5'd1);
    load_and_start();
    repeat (30) @(negedge clk);
    chk(cm_n == 7, "R9", "commit count (no x0 commit)", cm_n, 7);
    expect_commit(0, 5'd1, 32'd7, 4, "R3");
    expect_commit(1, 5'd2, 32'd5, 5, "R3");
    expect_commit(2, 5'd3, 32'd12, 7, "R4");
    expect_commit(3, 5'd3, 32'd19, 8, "R4");
    expect_commit(4, 5'd3, 32'd24, 9, "R5");
    expect_commit(5, 5'd4, 32'd24, 10, "R9");
    expect_commit(6, 5'd5, 32'd7, 12, "R9");
  endtask

  task automatic test_load_use();
    clear_bufs();
    dat[1] = 32'd5; dat[5] = 32'd24;
    prog[0] = i_ins(OP_LW, 5'd9, 5'd0, 16'd20);
    prog[1] = i_ins(OP_LW, 5'd1, 5'd0, 16'd4);
    prog[2] = r_ins(F_ADD, 5'd2, 5'd1, 5'd1);
    prog[3] = i_ins(OP_SW, 5'd2, 5'd0, 16'd16);
    prog[4] = i_ins(OP_LW, 5'd3, 5'd0, 16'd16);
    prog[5] = r_ins(F_SUB, 5'd4, 5'd3, 5'd1);
    prog[6] = i_ins(OP_SW, 5'd4, 5'd9, 16'hFFF8);
    load_and_start();
    repeat (30) @(negedge clk);
    chk(cm_n == 5, "R6", "commit count load-use", cm_n, 5);
    expect_commit(0, 5'd9, 32'd24, 4, "R3");
    expect_commit(1, 5'd1, 32'd5, 5, "R3");
    expect_commit(2, 5'd2, 32'd10, 7, "R6");
    expect_commit(3, 5'd3, 32'd10, 9, "R3");
    expect_commit(4, 5'd4, 32'd5, 11, "R6");
    chk(st_n == 2, "R3", "store count", st_n, 2);
    expect_store(0, 32'd16, 32'd10, 7, "R3");
    expect_store(1, 32'd16, 32'd5, 11, "R3");
  endtask

  task automatic test_branches();
    clear_bufs();
    dat[0] = 32'd7; dat[1] = 32'd5; dat[2] = 32'd7;
    prog[0]  = i_ins(OP_LW, 5'd1, 5'd0, 16'd0);
    prog[1]  = i_ins(OP_LW, 5'd2, 5'd0, 16'd4);
    prog[2]  = i_ins(OP_LW, 5'd3, 5'd0, 16'd8);
    prog[5]  = i_ins(OP_BEQ, 5'd2, 5'd1, 16'd2);
    prog[6]  = r_ins(F_ADD, 5'd4, 5'd1, 5'd2);
    prog[7]  = i_ins(OP_BEQ, 5'd3, 5'd1, 16'd2);
    prog[8]  = r_ins(F_ADD, 5'd5, 5'd1, 5'd1);
    prog[9]  = r_ins(F_ADD, 5'd6, 5'd1, 5'd1);
    prog[10] = r_ins(F_SUB, 5'd7, 5'd1, 5'd2);
    prog[11] = r_ins(F_ADD, 5'd8, 5'd1, 5'd2);
    prog[12] = i_ins(OP_BEQ, 5'd4, 5'd8, 16'd1);
    prog[13] = r_ins(F_ADD, 5'd5, 5'd1, 5'd1);
    prog[14] = i_ins(OP_LW, 5'd10, 5'd0, 16'd0);
    prog[15] = i_ins(OP_BEQ, 5'd1, 5'd10, 16'd1);
    prog[16] = r_ins(F_ADD, 5'd6, 5'd1, 5'd1);
    prog[17] = r_ins(F_OR, 5'd11, 5'd1, 5'd2);
    load_and_start();
    repeat (10) @(negedge clk);
    chk(fetch_pc == 32'd40, "R7", "taken target pc", fetch_pc, 32'd40);
    repeat (30) @(negedge clk);
    chk(cm_n == 8, "R7", "commit count branches", cm_n, 8);
    expect_commit(0, 5'd1, 32'd7, 4, "R3");
    expect_commit(1, 5'd2, 32'd5, 5, "R3");
    expect_commit(2, 5'd3, 32'd7, 6, "R3");
    expect_commit(3, 5'd4, 32'd12, 11, "R7");
    expect_commit(4, 5'd7, 32'd2, 14, "R7");
    expect_commit(5, 5'd8, 32'd12, 15, "R7");
    expect_commit(6, 5'd10, 32'd7, 19, "R8");
    expect_commit(7, 5'd11, 32'd7, 24, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_alu_chain();
    test_priority_zero();
    test_load_use();
    test_branches();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule